// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core (MIPS Subset)

This block is a 32-bit in-order integer core. Its pipeline has five stages: fetch, decode, execute, memory and writeback, with a register between each neighbouring pair. It runs a small MIPS subset. The arithmetic group is add, sub, and, or, nor, slt, sll and addi. The memory group is lw and sw. The only control-flow instruction is beq. The core contains the register file, the ALU, the decoder, an operand forwarding network, a load-use interlock and the branch flush logic.

The core has two memory ports. An instruction port sends out a byte address and takes in a word in the same cycle. A data port sends out an address, write data and a write strobe, and takes in a read word in the same cycle. Fetch always moves on to the next sequential word, so every branch is treated as not taken. A beq is resolved in execute. When it is taken, the two younger instructions are squashed and fetch restarts at the branch target.

Top module: `mips5_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC becomes 0 and every pipeline register becomes a bubble. After release, `imem_addr` starts at 0 and `dmem_we` stays low until a real store reaches the memory stage, which is no earlier than the fourth cycle.
- R2: When there is no stall and no taken branch, `imem_addr` advances by 4 on each cycle.
- R3: R-format instructions have opcode 0 in bits 31:26. The fields are rs in bits 25:21, rt in 20:16 and rd in 15:11, and the function code sits in bits 5:0. The function codes are add 0x20, sub 0x22, and 0x24, or 0x25, nor 0x27 and slt 0x2A. The result goes to rd, and slt compares as signed.
- R4: addi has opcode 0x08. It writes rs plus the sign-extended bits 15:0 into rt. sll has function code 0x00 and writes rt shifted left by bits 10:6 into rd.
- R5: lw has opcode 0x23 and sw has opcode 0x2B. The byte address is rs plus the sign-extended immediate. lw writes the read word into rt, and sw drives rt onto `dmem_wdata` with `dmem_we` high for one cycle.
- R6: beq has opcode 0x04 and is resolved in execute. When rs equals rt, the two instructions fetched after it make no architectural change and fetch resumes at the beq's address + 4 + (sign-extended immediate << 2). A forward or a backward offset both work. When the branch is not taken, fetch continues sequentially without any gap.
- R7: An ALU or store operand is forwarded from the execute/memory register or from the memory/writeback register. When both of them write the needed register, the younger value (execute/memory) wins. Back-to-back dependent instructions need no stall.
- R8: Register 0 always reads as zero. Writes to it are dropped, and it is never a forwarding source.
- R9: When a lw in execute targets a source register of the instruction in decode, fetch holds its address for exactly one cycle and the dependent instruction then gets the loaded value.
- R10: A decode-stage read of the register being written back in the same cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_data | input | 32 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 32 | Byte address of the load or store in the memory stage |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle per store |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, valid in the same cycle |

## Verification
The assertions take for granted that both memories answer in the same cycle as the address, and that the instruction stream never changes while the core runs out of reset. They also assume every fetched word is either one of the supported encodings or zero, which acts as a no-op. The stimulus keeps within these limits. The bench models both memories as combinational word arrays indexed by address bits 9:2, writes programs and data only while reset is held, and pads every unused instruction slot with zeros. Stores in the bench programs use word-aligned addresses only, so the byte-offset bits the memory model ignores are always zero.

// File: rtl/mips5_pkg.sv
package mips5_pkg;

    localparam int XLEN    = 32;
    localparam int REG_AW  = 5;
    localparam int NREGS   = 1 << REG_AW;
    localparam int PC_STEP = XLEN / 8;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [REG_AW-1:0] ridx_t;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;

    localparam logic [5:0] FN_SLL = 6'h00;
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_NOR = 6'h27;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLT, ALU_SLL
    } alu_op_e;

    typedef enum logic [1:0] { FWD_REG, FWD_EXM, FWD_MWB } fwd_sel_e;

    typedef struct packed {
        logic    reg_write;
        logic    mem_read;
        logic    mem_write;
        logic    use_imm;
        logic    branch;
        logic    use_rt;
        alu_op_e alu_op;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '0;

    typedef struct packed {
        logic  valid;
        word_t pc4;
        word_t instr;
    } ifid_t;

    typedef struct packed {
        ctrl_t      ctrl;
        word_t      pc4;
        ridx_t      rs;
        ridx_t      rt;
        ridx_t      dst;
        word_t      rs_val;
        word_t      rt_val;
        word_t      imm;
        logic [4:0] shamt;
    } idex_t;

    typedef struct packed {
        logic  reg_write;
        logic  mem_read;
        logic  mem_write;
        ridx_t dst;
        word_t alu_y;
        word_t st_data;
    } exmem_t;

    typedef struct packed {
        logic  reg_write;
        logic  from_mem;
        ridx_t dst;
        word_t alu_y;
        word_t ld_data;
    } memwb_t;

    function automatic word_t sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic ridx_t dest_of(input word_t ins);
        return (ins[31:26] == OP_RTYPE) ? ins[15:11] : ins[20:16];
    endfunction

    function automatic ctrl_t decode(input word_t ins);
        ctrl_t c;
        c = CTRL_NOP;
        unique case (ins[31:26])
            OP_RTYPE: begin
                c.reg_write = 1'b1;
                c.use_rt    = 1'b1;
                case (ins[5:0])
                    FN_ADD:  c.alu_op = ALU_ADD;
                    FN_SUB:  c.alu_op = ALU_SUB;
                    FN_AND:  c.alu_op = ALU_AND;
                    FN_OR:   c.alu_op = ALU_OR;
                    FN_NOR:  c.alu_op = ALU_NOR;
                    FN_SLT:  c.alu_op = ALU_SLT;
                    FN_SLL:  c.alu_op = ALU_SLL;
                    default: c = CTRL_NOP;
                endcase
            end
            OP_ADDI: begin
                c.reg_write = 1'b1;
                c.use_imm   = 1'b1;
            end
            OP_LW: begin
                c.reg_write = 1'b1;
                c.mem_read  = 1'b1;
                c.use_imm   = 1'b1;
            end
            OP_SW: begin
                c.mem_write = 1'b1;
                c.use_imm   = 1'b1;
                c.use_rt    = 1'b1;
            end
            OP_BEQ: begin
                c.branch = 1'b1;
                c.use_rt = 1'b1;
                c.alu_op = ALU_SUB;
            end
            default: c = CTRL_NOP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mips5_regfile.sv
module mips5_regfile
    import mips5_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ridx_t ra_a,
    input  ridx_t ra_b,
    output word_t rd_a,
    output word_t rd_b,
    input  logic  we,
    input  ridx_t wa,
    input  word_t wd
);

    word_t regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    // read ports with same-cycle write-through; register 0 pinned to zero
    function automatic word_t rd_port(input ridx_t ra, input word_t stored,
                                      input logic w_en, input ridx_t w_a,
                                      input word_t w_d);
        if (ra == '0)                return '0;
        else if (w_en && w_a == ra)  return w_d;
        else                         return stored;
    endfunction

    assign rd_a = rd_port(ra_a, regs[ra_a], we, wa, wd);
    assign rd_b = rd_port(ra_b, regs[ra_b], we, wa, wd);

endmodule

// File: rtl/mips5_alu.sv
module mips5_alu
    import mips5_pkg::*;
(
    input  word_t      a,
    input  word_t      b,
    input  logic [4:0] shamt,
    input  alu_op_e    op,
    output word_t      y,
    output logic       zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_NOR: y = ~(a | b);
            ALU_SLT: y = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
            ALU_SLL: y = b << shamt;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mips5_fwd.sv
module mips5_fwd
    import mips5_pkg::*;
(
    input  ridx_t    src_a,
    input  ridx_t    src_b,
    input  logic     exm_we,
    input  ridx_t    exm_dst,
    input  logic     mwb_we,
    input  ridx_t    mwb_dst,
    output fwd_sel_e sel_a,
    output fwd_sel_e sel_b
);

    ridx_t    srcs [2];
    fwd_sel_e pick [2];

    assign srcs[0] = src_a;
    assign srcs[1] = src_b;

    for (genvar i = 0; i < 2; i++) begin : g_src
        always_comb begin
            if (srcs[i] != '0 && exm_we && exm_dst == srcs[i])
                pick[i] = FWD_EXM;
            else if (srcs[i] != '0 && mwb_we && mwb_dst == srcs[i])
                pick[i] = FWD_MWB;
            else
                pick[i] = FWD_REG;
        end
    end

    assign sel_a = pick[0];
    assign sel_b = pick[1];

endmodule

// File: rtl/mips5_hazard.sv
module mips5_hazard
    import mips5_pkg::*;
(
    input  logic  ex_mem_read,
    input  ridx_t ex_dst,
    input  ridx_t id_rs,
    input  ridx_t id_rt,
    input  logic  id_use_rt,
    output logic  stall
);

    logic hit_rs, hit_rt;

    assign hit_rs = (ex_dst == id_rs);
    assign hit_rt = id_use_rt && (ex_dst == id_rt);
    assign stall  = ex_mem_read && (ex_dst != '0) && (hit_rs || hit_rt);

endmodule

// File: rtl/mips5_core.sv
module mips5_core
    import mips5_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_data,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata
);

    word_t  pc_q;
    ifid_t  ifid_q;
    idex_t  idex_q;
    exmem_t exmem_q;
    memwb_t memwb_q;

    // ---------------- decode ----------------
    word_t id_ins;
    ctrl_t id_ctrl;
    ridx_t id_rs, id_rt;
    word_t id_rs_val, id_rt_val;
    logic  stall;

    assign id_ins  = ifid_q.instr;
    assign id_ctrl = ifid_q.valid ? decode(id_ins) : CTRL_NOP;
    assign id_rs   = id_ins[25:21];
    assign id_rt   = id_ins[20:16];

    // ---------------- writeback ----------------
    word_t wb_data;
    assign wb_data = memwb_q.from_mem ? memwb_q.ld_data : memwb_q.alu_y;

    mips5_regfile u_rf (
        .clk (clk),
        .rst (rst),
        .ra_a(id_rs),
        .ra_b(id_rt),
        .rd_a(id_rs_val),
        .rd_b(id_rt_val),
        .we  (memwb_q.reg_write),
        .wa  (memwb_q.dst),
        .wd  (wb_data)
    );

    mips5_hazard u_hz (
        .ex_mem_read(idex_q.ctrl.mem_read),
        .ex_dst     (idex_q.dst),
        .id_rs      (id_rs),
        .id_rt      (id_rt),
        .id_use_rt  (id_ctrl.use_rt),
        .stall      (stall)
    );

    // ---------------- execute ----------------
    fwd_sel_e fwd_a, fwd_b;
    word_t    op_a, op_b_reg, op_b, ex_y, br_target;
    logic     ex_zero, br_taken;

    mips5_fwd u_fwd (
        .src_a  (idex_q.rs),
        .src_b  (idex_q.rt),
        .exm_we (exmem_q.reg_write),
        .exm_dst(exmem_q.dst),
        .mwb_we (memwb_q.reg_write),
        .mwb_dst(memwb_q.dst),
        .sel_a  (fwd_a),
        .sel_b  (fwd_b)
    );

    function automatic word_t fwd_mux(input fwd_sel_e s, input word_t rf,
                                      input word_t exm, input word_t mwb);
        unique case (s)
            FWD_EXM: return exm;
            FWD_MWB: return mwb;
            default: return rf;
        endcase
    endfunction

    assign op_a     = fwd_mux(fwd_a, idex_q.rs_val, exmem_q.alu_y, wb_data);
    assign op_b_reg = fwd_mux(fwd_b, idex_q.rt_val, exmem_q.alu_y, wb_data);
    assign op_b     = idex_q.ctrl.use_imm ? idex_q.imm : op_b_reg;

    mips5_alu u_alu (
        .a    (op_a),
        .b    (op_b),
        .shamt(idex_q.shamt),
        .op   (idex_q.ctrl.alu_op),
        .y    (ex_y),
        .zero (ex_zero)
    );

    assign br_taken  = idex_q.ctrl.branch && ex_zero;
    assign br_target = idex_q.pc4 + (idex_q.imm << 2);

    // ---------------- memory port ----------------
    assign imem_addr  = pc_q;
    assign dmem_addr  = exmem_q.alu_y;
    assign dmem_wdata = exmem_q.st_data;
    assign dmem_we    = exmem_q.mem_write;

    // ---------------- pipeline registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            ifid_q  <= '0;
            idex_q  <= '0;
            exmem_q <= '0;
            memwb_q <= '0;
        end else begin
            exmem_q <= '{reg_write: idex_q.ctrl.reg_write,
                         mem_read:  idex_q.ctrl.mem_read,
                         mem_write: idex_q.ctrl.mem_write,
                         dst:       idex_q.dst,
                         alu_y:     ex_y,
                         st_data:   op_b_reg};
            memwb_q <= '{reg_write: exmem_q.reg_write,
                         from_mem:  exmem_q.mem_read,
                         dst:       exmem_q.dst,
                         alu_y:     exmem_q.alu_y,
                         ld_data:   dmem_rdata};
            if (br_taken) begin
                pc_q   <= br_target;
                ifid_q <= '0;
                idex_q <= '0;
            end else if (stall) begin
                idex_q <= '0;
            end else begin
                pc_q   <= pc_q + word_t'(PC_STEP);
                ifid_q <= '{valid: 1'b1, pc4: pc_q + word_t'(PC_STEP),
                            instr: imem_data};
                idex_q <= '{ctrl:   id_ctrl,
                            pc4:    ifid_q.pc4,
                            rs:     id_rs,
                            rt:     id_rt,
                            dst:    dest_of(id_ins),
                            rs_val: id_rs_val,
                            rt_val: id_rt_val,
                            imm:    sext16(id_ins[15:0]),
                            shamt:  id_ins[10:6]};
            end
        end
    end

    // ---------------- assertions ----------------
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dmem_we && imem_addr == '0));  // R1

    AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
        (!stall && !br_taken) |=> (imem_addr == $past(imem_addr) + 32'd4));  // R2

    AST_STALL_HOLDS_FETCH: assert property (@(posedge clk) disable iff (rst)
        (stall && !br_taken) |=> $stable(imem_addr));  // R9

    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
        br_taken |=> (imem_addr == $past(idex_q.pc4) + {$past(idex_q.imm[29:0]), 2'b00}));  // R6

    AST_FLUSH_SILENT: assert property (@(posedge clk) disable iff (rst)
        br_taken |=> ##1 (!exmem_q.reg_write && !exmem_q.mem_write));  // R6

    AST_YOUNGEST_WINS: assert property (@(posedge clk) disable iff (rst)
        (exmem_q.reg_write && exmem_q.dst == idex_q.rs && idex_q.rs != '0)
            |-> (fwd_a == FWD_EXM));  // R7

    AST_NO_ZERO_FWD_A: assert property (@(posedge clk) disable iff (rst)
        (fwd_a != FWD_REG) |-> (idex_q.rs != '0));  // R8

    AST_NO_ZERO_FWD_B: assert property (@(posedge clk) disable iff (rst)
        (fwd_b != FWD_REG) |-> (idex_q.rt != '0));  // R8

endmodule

// File: tb/tb_mips5_core.sv
module tb_mips5_core;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int MEMW       = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [MEMW];
    logic [31:0] dmem [MEMW];
    logic [31:0] trace [128];

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mips5_core dut (
        .clk       (clk),
        .rst       (rst),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .dmem_addr (dmem_addr),
        .dmem_wdata(dmem_wdata),
        .dmem_we   (dmem_we),
        .dmem_rdata(dmem_rdata)
    );

    assign imem_data  = imem[imem_addr[9:2]];
    assign dmem_rdata = dmem[dmem_addr[9:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[9:2]] = dmem_wdata;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- encoders ----------------
    function automatic logic [31:0] enc_r(logic [5:0] fn, int rs, int rt, int rd, int sh);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    localparam logic [31:0] NOP = 32'h0;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MEMW; i++) begin
            imem[i] = NOP;
            dmem[i] = 32'h0;
        end
    endtask

    task automatic run(int ncyc);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "fetch address in reset", imem_addr, 32'h0);
        check("R1", "store strobe in reset", {31'h0, dmem_we}, 32'h0);
        rst = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            if (k < 128) trace[k] = imem_addr;
            if (k < 3) check("R1", "no store right after reset", {31'h0, dmem_we}, 32'h0);
            @(negedge clk);
        end
        rst = 1'b1;
        @(negedge clk);
    endtask

    // ---------------- program A: arithmetic, forwarding, load-use ----------------
    task automatic arith_case(logic [31:0] a, logic [31:0] b);
        logic [31:0] e3, e4, e10, e11, e12;
        clear_mem();
        dmem[0]  = a;
        dmem[1]  = b;
        dmem[41] = 32'hDEAD_BEEF;
        dmem[42] = 32'hDEAD_BEEF;
        imem[0]  = enc_i(6'h23, 0, 1, 0);
        imem[1]  = enc_i(6'h23, 0, 2, 4);
        imem[2]  = NOP;
        imem[3]  = enc_r(6'h20, 1, 2, 3, 0);
        imem[4]  = enc_r(6'h22, 1, 2, 4, 0);
        imem[5]  = enc_r(6'h24, 1, 2, 5, 0);
        imem[6]  = enc_r(6'h25, 1, 2, 6, 0);
        imem[7]  = enc_r(6'h27, 1, 2, 7, 0);
        imem[8]  = enc_r(6'h2A, 1, 2, 8, 0);
        imem[9]  = enc_r(6'h2A, 2, 1, 9, 0);
        imem[10] = enc_i(6'h08, 1, 10, -5);
        imem[11] = enc_r(6'h00, 0, 1, 11, 7);
        imem[12] = enc_r(6'h20, 3, 11, 12, 0);
        imem[13] = enc_r(6'h22, 12, 10, 13, 0);
        imem[14] = enc_r(6'h20, 12, 12, 14, 0);
        for (int k = 3; k <= 14; k++) imem[12+k] = enc_i(6'h2B, 0, k, 4*(16+k));
        imem[27] = enc_i(6'h08, 0, 15, 1);
        imem[28] = enc_i(6'h08, 0, 15, 2);
        imem[29] = enc_r(6'h20, 15, 15, 16, 0);
        imem[30] = enc_i(6'h2B, 0, 16, 160);
        imem[31] = enc_i(6'h08, 0, 0, 55);
        imem[32] = enc_r(6'h20, 0, 0, 17, 0);
        imem[33] = enc_i(6'h2B, 0, 17, 164);
        imem[34] = enc_i(6'h2B, 0, 0, 168);
        imem[35] = enc_i(6'h23, 0, 18, 0);
        imem[36] = enc_r(6'h20, 18, 18, 19, 0);
        imem[37] = enc_i(6'h2B, 0, 19, 172);
        run(60);

        e3  = a + b;
        e4  = a - b;
        e10 = a + 32'hFFFF_FFFB;
        e11 = a << 7;
        e12 = e3 + e11;
        check("R3", "add", dmem[19], e3);
        check("R3", "sub", dmem[20], e4);
        check("R3", "and", dmem[21], a & b);
        check("R3", "or",  dmem[22], a | b);
        check("R3", "nor", dmem[23], ~(a | b));
        check("R3", "slt a<b", dmem[24], ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        check("R3", "slt b<a", dmem[25], ($signed(b) < $signed(a)) ? 32'd1 : 32'd0);
        check("R4", "addi negative imm", dmem[26], e10);
        check("R4", "sll by 7", dmem[27], e11);
        check("R7", "ex/mem forward chain", dmem[28], e12);
        check("R10", "writeback same-cycle read", dmem[29], e12 - e10);
        check("R7", "mem/wb forward", dmem[30], e12 + e12);
        check("R7", "younger value wins", dmem[40], 32'd4);
        check("R8", "r0 not forwarded", dmem[41], 32'h0);
        check("R8", "r0 reads zero", dmem[42], 32'h0);
        check("R9", "load-use result", dmem[43], a + a);
        check("R5", "lw source untouched", dmem[0], a);
        check("R2", "sequential fetch", trace[5], 32'd20);
        check("R9", "fetch before stall", trace[37], 32'd148);
        check("R9", "fetch held one cycle", trace[38], 32'd148);
        check("R9", "fetch resumes", trace[39], 32'd152);
    endtask

    // ---------------- program B: branches ----------------
    task automatic branch_case();
        clear_mem();
        dmem[0]  = 32'd5;
        dmem[38] = 32'hDEAD_BEEF;
        imem[0]  = enc_i(6'h08, 0, 1, 5);
        imem[1]  = enc_i(6'h08, 0, 2, 5);
        imem[2]  = enc_i(6'h04, 1, 2, 3);
        imem[3]  = enc_i(6'h08, 0, 3, 11);
        imem[4]  = enc_i(6'h08, 0, 4, 12);
        imem[5]  = enc_i(6'h08, 0, 5, 13);
        imem[6]  = enc_i(6'h08, 0, 6, 21);
        imem[7]  = enc_i(6'h04, 1, 0, 2);
        imem[8]  = enc_i(6'h08, 0, 7, 22);
        imem[9]  = enc_i(6'h08, 0, 10, 3);
        imem[10] = enc_i(6'h08, 9, 9, 1);
        imem[11] = enc_i(6'h04, 9, 10, 1);
        imem[12] = enc_i(6'h04, 0, 0, -3);
        imem[13] = enc_i(6'h08, 0, 12, 400);
        imem[14] = enc_i(6'h2B, 12, 6, -4);
        imem[15] = enc_i(6'h2B, 0, 3, 128);
        imem[16] = enc_i(6'h2B, 0, 4, 132);
        imem[17] = enc_i(6'h2B, 0, 5, 136);
        imem[18] = enc_i(6'h2B, 0, 6, 140);
        imem[19] = enc_i(6'h2B, 0, 7, 144);
        imem[20] = enc_i(6'h2B, 0, 9, 148);
        imem[21] = enc_i(6'h23, 0, 11, 0);
        imem[22] = enc_i(6'h04, 11, 1, 1);
        imem[23] = enc_i(6'h08, 0, 13, 99);
        imem[24] = enc_i(6'h2B, 0, 13, 152);
        run(80);

        check("R6", "flushed slot 1", dmem[32], 32'h0);
        check("R6", "flushed slot 2", dmem[33], 32'h0);
        check("R6", "skipped instruction", dmem[34], 32'h0);
        check("R6", "branch target executed", dmem[35], 32'd21);
        check("R6", "not-taken fall-through", dmem[36], 32'd22);
        check("R6", "backward loop count", dmem[37], 32'd3);
        check("R9", "load-use into taken beq", dmem[38], 32'h0);
        check("R5", "negative store offset", dmem[99], 32'd21);
        check("R2", "fetch before branch resolves", trace[3], 32'd12);
        check("R6", "flushed fetch address", trace[4], 32'd16);
        check("R6", "forward target fetch", trace[5], 32'd24);
        check("R6", "not-taken no gap", trace[9], 32'd40);
        check("R6", "backward target fetch", trace[14], 32'd40);
    endtask

    initial begin
        arith_case(32'd5, 32'd3);
        arith_case(32'd3, 32'd5);
        arith_case(32'hFFFF_FFF9, 32'd2);
        arith_case(32'h8000_0000, 32'd1);
        arith_case(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        arith_case(32'h1234_5678, 32'h0F0F_F0F0);
        branch_case();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule